// File: doc/BRIEF.md
# Configuration Lock Arbiter and Start Controller

This block holds a host-writable control word and turns it into the signals that steer a configuration subsystem. Two parties share one storage device: an internal configuration engine and a microprocessor host. The block arbitrates between them, and a force bit can take the storage for the host with no arbitration at all. The block also picks the effective configuration mode and address. Each one comes either from external pins or from register bits.

The block starts configuration with a one-cycle pulse. The pulse fires on its own after reset when the effective mode asks for it. Otherwise it fires when the host writes the start bit. A reset bit holds the downstream controllers in reset and asks the storage card for a soft reset. When the reset bit is cleared, the automatic start is armed again. Two enables gate the buffer-ready and error events onto one level-sensitive interrupt.

The host writes the whole word in one cycle with `wr_en` and reads it back on `rd_data`. The start bit always reads back as 0.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: After `rst_n` is low, `rd_data` is 0, both grants are 0, `irq` is 0, and `ctl_reset`, `card_soft_reset` and `cfg_start` are 0.
- R2: While force-lock (bit 1) is 1, `eng_grant` is 0 and `host_grant` equals lock-request (bit 0). Both follow one cycle after the register holds the value.
- R3: With force-lock at 0 and no owner, a lone requester is granted one cycle later. When the engine and the host (lock-request, bit 0) both ask in the same cycle, the engine wins.
- R4: An owner keeps its grant until its own request drops, whatever the other side requests. The host releases the lock only after lock-request is cleared. On release, a pending request from the other side is granted on the next cycle.
- R5: When force-address (bit 4) is 0, `cfg_addr` equals the zero-extended `addr_pin`. When it is 1, `cfg_addr` equals register bits 15:13.
- R6: When force-mode (bit 3) is 0, `cfg_mode` equals `mode_pin`. When it is 1, `cfg_mode` equals the mode bit (bit 2).
- R7: `cfg_start` pulses high for exactly one cycle, in the first cycle after `rst_n` releases, when `cfg_mode` is 1. When `cfg_mode` is 0 it stays low.
- R8: Writing 1 to the start bit (bit 5) makes `cfg_start` high for exactly the next cycle. The start bit reads back as 0.
- R9: `cfg_src` equals the source-select bit (bit 6): 0 selects the card, 1 selects the host port.
- R10: `ctl_reset` and `card_soft_reset` equal the reset bit (bit 7). While the bit is 1, the lock owner is cleared and no start pulse occurs. Clearing the bit re-arms the automatic start of R7, which then fires one cycle later.
- R11: `irq` = (`buf_rdy_evt` AND bit 9) OR (`err_evt` AND bit 8). It is purely combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Control word readback (start bit reads 0) |
| eng_req | input | 1 | Configuration engine storage request |
| eng_grant | output | 1 | Storage granted to the engine |
| host_grant | output | 1 | Storage granted to the host |
| mode_pin | input | 1 | External configuration mode pin |
| addr_pin | input | 2 | External configuration address pins |
| cfg_mode | output | 1 | Effective configuration mode |
| cfg_addr | output | 3 | Effective configuration address |
| cfg_src | output | 1 | Configuration data source select |
| cfg_start | output | 1 | One-cycle configuration start pulse |
| ctl_reset | output | 1 | Reset to the configuration and storage controllers |
| card_soft_reset | output | 1 | Soft-reset request to the storage card |
| buf_rdy_evt | input | 1 | Data buffer ready event |
| err_evt | input | 1 | Error event |
| irq | output | 1 | Gated interrupt |

## Verification
The two override muxes are swept over every combination of force bit, register field and pin value. This shows whether the pin path or the register path is selected, and whether the pins are zero-extended.

The interrupt gate is swept across all sixteen pairings of enable and event, which separates the two enables from each other.

Arbitration is driven through three scenarios:
- the engine holding the lock while the host asks;
- a handover in both directions;
- a true same-cycle tie, set up by releasing a controller reset.

Force mode is then toggled while the engine keeps requesting. Start pulses are observed after a power-on release under both pin modes, after a start write, and after the reset bit clears.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
   localparam int REG_W      = 16;
   localparam int CFG_ADDR_W = 3;
   localparam int B_LOCK     = 0;
   localparam int B_FLOCK    = 1;
   localparam int B_MODE     = 2;
   localparam int B_FMODE    = 3;
   localparam int B_FADDR    = 4;
   localparam int B_START    = 5;
   localparam int B_SRC      = 6;
   localparam int B_CRST     = 7;
   localparam int B_ERREN    = 8;
   localparam int B_BUFEN    = 9;
   localparam int B_ADDR_LO  = 13;

   typedef enum logic [1:0] {OWN_NONE, OWN_ENG, OWN_HOST} owner_e;

   typedef struct packed {
      logic [CFG_ADDR_W-1:0] addr;
      logic buf_en;
      logic err_en;
      logic crst;
      logic src;
      logic faddr;
      logic fmode;
      logic mode;
      logic flock;
      logic lock;
   } ctrl_t;

   function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
      ctrl_t c;
      c.addr   = w[B_ADDR_LO +: CFG_ADDR_W];
      c.buf_en = w[B_BUFEN];
      c.err_en = w[B_ERREN];
      c.crst   = w[B_CRST];
      c.src    = w[B_SRC];
      c.faddr  = w[B_FADDR];
      c.fmode  = w[B_FMODE];
      c.mode   = w[B_MODE];
      c.flock  = w[B_FLOCK];
      c.lock   = w[B_LOCK];
      return c;
   endfunction

   function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
      logic [REG_W-1:0] w;
      w = '0;
      w[B_ADDR_LO +: CFG_ADDR_W] = c.addr;
      w[B_BUFEN] = c.buf_en;
      w[B_ERREN] = c.err_en;
      w[B_CRST]  = c.crst;
      w[B_SRC]   = c.src;
      w[B_FADDR] = c.faddr;
      w[B_FMODE] = c.fmode;
      w[B_MODE]  = c.mode;
      w[B_FLOCK] = c.flock;
      w[B_LOCK]  = c.lock;
      return w;
   endfunction
endpackage

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
   import cfg_lock_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             eff_mode,
   output ctrl_t            ctrl,
   output logic [REG_W-1:0] rd_data,
   output logic             start_pulse
);
   ctrl_t ctrl_q;
   logic  armed_q;
   logic  start_wr;
   logic  unused_bits;

   assign start_wr    = wr_en && wr_data[B_START];
   assign unused_bits = ^wr_data[B_ADDR_LO-1:B_BUFEN+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         armed_q     <= 1'b1;
         start_pulse <= 1'b0;
      end else begin
         if (wr_en) ctrl_q <= word_to_ctrl(wr_data);
         start_pulse <= !ctrl_q.crst && ((armed_q && eff_mode) || start_wr);
         armed_q     <= ctrl_q.crst;
      end
   end

   assign ctrl    = ctrl_q;
   assign rd_data = ctrl_to_word(ctrl_q);
endmodule

// File: rtl/cfg_lock_arb.sv
module cfg_lock_arb
   import cfg_lock_pkg::*;
#(
   parameter bit ENG_WINS_TIE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic force_lock,
   input  logic eng_req,
   input  logic host_req,
   output logic eng_grant,
   output logic host_grant
);
   owner_e own_q, own_d, pick;

   generate
      if (ENG_WINS_TIE) begin : g_eng_first
         always_comb
            pick = eng_req ? OWN_ENG : (host_req ? OWN_HOST : OWN_NONE);
      end else begin : g_host_first
         always_comb
            pick = host_req ? OWN_HOST : (eng_req ? OWN_ENG : OWN_NONE);
      end
   endgenerate

   always_comb begin
      if (force_lock)
         own_d = host_req ? OWN_HOST : OWN_NONE;
      else if (own_q == OWN_ENG && eng_req)
         own_d = OWN_ENG;
      else if (own_q == OWN_HOST && host_req)
         own_d = OWN_HOST;
      else
         own_d = pick;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) own_q <= OWN_NONE;
      else               own_q <= own_d;
   end

   assign eng_grant  = (own_q == OWN_ENG);
   assign host_grant = (own_q == OWN_HOST);
endmodule

// File: rtl/cfg_src_mux.sv
module cfg_src_mux
   import cfg_lock_pkg::*;
#(
   parameter int PIN_ADDR_W = 2
) (
   input  logic                  force_mode,
   input  logic                  reg_mode,
   input  logic                  mode_pin,
   input  logic                  force_addr,
   input  logic [CFG_ADDR_W-1:0] reg_addr,
   input  logic [PIN_ADDR_W-1:0] addr_pin,
   input  logic                  buf_en,
   input  logic                  err_en,
   input  logic                  buf_rdy_evt,
   input  logic                  err_evt,
   output logic                  eff_mode,
   output logic [CFG_ADDR_W-1:0] eff_addr,
   output logic                  irq
);
   logic [CFG_ADDR_W-1:0] pin_ext;

   generate
      if (PIN_ADDR_W == CFG_ADDR_W) begin : g_pin_full
         assign pin_ext = addr_pin;
      end else begin : g_pin_ext
         assign pin_ext = {{(CFG_ADDR_W-PIN_ADDR_W){1'b0}}, addr_pin};
      end
   endgenerate

   assign eff_mode = force_mode ? reg_mode : mode_pin;
   assign eff_addr = force_addr ? reg_addr : pin_ext;
   assign irq      = (buf_rdy_evt && buf_en) || (err_evt && err_en);
endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
   import cfg_lock_pkg::*;
#(
   parameter int PIN_ADDR_W   = 2,
   parameter bit ENG_WINS_TIE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_W-1:0]      wr_data,
   output logic [REG_W-1:0]      rd_data,
   input  logic                  eng_req,
   output logic                  eng_grant,
   output logic                  host_grant,
   input  logic                  mode_pin,
   input  logic [PIN_ADDR_W-1:0] addr_pin,
   output logic                  cfg_mode,
   output logic [CFG_ADDR_W-1:0] cfg_addr,
   output logic                  cfg_src,
   output logic                  cfg_start,
   output logic                  ctl_reset,
   output logic                  card_soft_reset,
   input  logic                  buf_rdy_evt,
   input  logic                  err_evt,
   output logic                  irq
);
   generate
      if (PIN_ADDR_W < 1 || PIN_ADDR_W > CFG_ADDR_W) begin : g_bad_pin_w
         $error("PIN_ADDR_W must lie in 1..CFG_ADDR_W");
      end
      if (REG_W < B_ADDR_LO + CFG_ADDR_W) begin : g_bad_reg_w
         $error("control word too narrow for the address field");
      end
   endgenerate

   ctrl_t ctrl;

   cfg_ctrl_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .eff_mode   (cfg_mode),
      .ctrl       (ctrl),
      .rd_data    (rd_data),
      .start_pulse(cfg_start)
   );

   cfg_lock_arb #(.ENG_WINS_TIE(ENG_WINS_TIE)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctrl.crst),
      .force_lock(ctrl.flock),
      .eng_req   (eng_req),
      .host_req  (ctrl.lock),
      .eng_grant (eng_grant),
      .host_grant(host_grant)
   );

   cfg_src_mux #(.PIN_ADDR_W(PIN_ADDR_W)) u_mux (
      .force_mode (ctrl.fmode),
      .reg_mode   (ctrl.mode),
      .mode_pin   (mode_pin),
      .force_addr (ctrl.faddr),
      .reg_addr   (ctrl.addr),
      .addr_pin   (addr_pin),
      .buf_en     (ctrl.buf_en),
      .err_en     (ctrl.err_en),
      .buf_rdy_evt(buf_rdy_evt),
      .err_evt    (err_evt),
      .eff_mode   (cfg_mode),
      .eff_addr   (cfg_addr),
      .irq        (irq)
   );

   assign cfg_src         = ctrl.src;
   assign ctl_reset       = ctrl.crst;
   assign card_soft_reset = ctrl.crst;
endmodule

// File: rtl/cfg_lock_ctrl_chk.sv
module cfg_lock_ctrl_chk
   import cfg_lock_pkg::*;
#(
   parameter int PIN_ADDR_W = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [REG_W-1:0]      rd_data,
   input logic                  eng_req,
   input logic                  eng_grant,
   input logic                  host_grant,
   input logic [CFG_ADDR_W-1:0] cfg_addr,
   input logic                  cfg_start,
   input logic                  ctl_reset
);
   a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_grant && host_grant));

   a_r2_force_starves_engine: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[B_FLOCK] |=> !eng_grant);

   a_r4_host_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
      (host_grant && rd_data[B_LOCK] && !rd_data[B_CRST]) |=> host_grant);

   a_r4_engine_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_grant && eng_req && !rd_data[B_FLOCK] && !rd_data[B_CRST]) |=> eng_grant);

   a_r10_no_start_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_reset |=> !cfg_start);

   a_r5_pin_addr_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[B_FADDR] |-> ((cfg_addr >> PIN_ADDR_W) == '0));
endmodule

bind cfg_lock_ctrl cfg_lock_ctrl_chk #(.PIN_ADDR_W(PIN_ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_data   (rd_data),
   .eng_req   (eng_req),
   .eng_grant (eng_grant),
   .host_grant(host_grant),
   .cfg_addr  (cfg_addr),
   .cfg_start (cfg_start),
   .ctl_reset (ctl_reset)
);

// File: tb/sim_cfg_lock_ctrl.sv
module sim_cfg_lock_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n, wr_en, eng_req, mode_pin, buf_rdy_evt, err_evt;
   logic [15:0] wr_data, rd_data;
   logic [1:0]  addr_pin;
   logic [2:0]  cfg_addr;
   logic        eng_grant, host_grant, cfg_mode, cfg_src, cfg_start;
   logic        ctl_reset, card_soft_reset, irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   cfg_lock_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .eng_req(eng_req), .eng_grant(eng_grant), .host_grant(host_grant),
      .mode_pin(mode_pin), .addr_pin(addr_pin), .cfg_mode(cfg_mode), .cfg_addr(cfg_addr),
      .cfg_src(cfg_src), .cfg_start(cfg_start), .ctl_reset(ctl_reset),
      .card_soft_reset(card_soft_reset), .buf_rdy_evt(buf_rdy_evt), .err_evt(err_evt),
      .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int seen;
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; eng_req = 1'b0;
      mode_pin = 1'b1; addr_pin = '0; buf_rdy_evt = 1'b0; err_evt = 1'b0;
      repeat (3) step();
      // R1 reset state
      chk("R1 rd_data", rd_data, 0);
      chk("R1 grants", {eng_grant, host_grant}, 0);
      chk("R1 resets", {ctl_reset, card_soft_reset, cfg_start}, 0);
      buf_rdy_evt = 1'b1; err_evt = 1'b1;
      #1 chk("R1 irq", irq, 0);
      buf_rdy_evt = 1'b0; err_evt = 1'b0;
      // R7 auto start with mode pin high
      rst_n = 1'b1;
      step(); chk("R7 auto pulse", cfg_start, 1);
      step(); chk("R7 pulse width", cfg_start, 0);
      step(); chk("R7 no repeat", cfg_start, 0);
      // R7 no auto start with mode pin low
      rst_n = 1'b0; mode_pin = 1'b0;
      repeat (2) step();
      rst_n = 1'b1;
      seen = 0;
      for (int i = 0; i < 4; i++) begin step(); seen += cfg_start; end
      chk("R7 no pulse mode0", seen, 0);

      // R5 address source sweep
      for (int f = 0; f < 2; f++)
         for (int a = 0; a < 8; a++)
            for (int p = 0; p < 4; p++) begin
               addr_pin = p[1:0];
               wr(16'((a << 13) | (f << 4)));
               #1 chk("R5 cfg_addr", cfg_addr, (f != 0) ? a : p);
            end

      // R6 mode source sweep
      for (int fm = 0; fm < 2; fm++)
         for (int mb = 0; mb < 2; mb++)
            for (int p = 0; p < 2; p++) begin
               mode_pin = p[0];
               wr(16'((fm << 3) | (mb << 2)));
               #1 chk("R6 cfg_mode", cfg_mode, (fm != 0) ? mb : p);
            end
      mode_pin = 1'b0;

      // R9 source select
      wr(16'h0040); chk("R9 src host", cfg_src, 1);
      wr(16'h0000); chk("R9 src card", cfg_src, 0);

      // R11 interrupt gating sweep
      for (int en = 0; en < 4; en++)
         for (int ev = 0; ev < 4; ev++) begin
            wr(16'(en << 8));
            err_evt = ev[0]; buf_rdy_evt = ev[1];
            #1 chk("R11 irq", irq, (ev[1] & en[1]) | (ev[0] & en[0]));
         end
      err_evt = 1'b0; buf_rdy_evt = 1'b0;

      // R8 start write
      wr(16'h0020);
      chk("R8 start pulse", cfg_start, 1);
      chk("R8 start reads 0", rd_data[5], 0);
      step(); chk("R8 pulse width", cfg_start, 0);

      // R10 reset bit with forced mode 1
      wr(16'h008C);
      chk("R10 ctl_reset", ctl_reset, 1);
      chk("R10 card reset", card_soft_reset, 1);
      chk("R10 no start", cfg_start, 0);
      wr(16'h000C);
      chk("R10 ctl_reset clear", ctl_reset, 0);
      chk("R10 start wait", cfg_start, 0);
      step(); chk("R10 rearmed pulse", cfg_start, 1);
      step(); chk("R10 pulse width", cfg_start, 0);
      wr(16'h0000);

      // R3 lone engine request
      eng_req = 1'b1;
      step(); chk("R3 engine granted", {eng_grant, host_grant}, 2);
      // R4 engine holds while host asks
      wr(16'h0001);
      step(); chk("R4 engine holds", {eng_grant, host_grant}, 2);
      eng_req = 1'b0;
      step(); chk("R4 handover to host", {eng_grant, host_grant}, 1);
      eng_req = 1'b1;
      step(); chk("R4 host holds", {eng_grant, host_grant}, 1);
      wr(16'h0000);
      step(); chk("R4 host release", {eng_grant, host_grant}, 2);

      // R10 owner cleared, then R3 tie
      wr(16'h0081);
      step(); chk("R10 owner cleared", {eng_grant, host_grant}, 0);
      wr(16'h0001);
      step(); chk("R3 tie engine wins", {eng_grant, host_grant}, 2);

      // R2 force lock with engine still requesting
      wr(16'h0002);
      step(); chk("R2 force idle", {eng_grant, host_grant}, 0);
      wr(16'h0003);
      step(); chk("R2 force host", {eng_grant, host_grant}, 1);
      wr(16'h0002);
      step(); chk("R2 force drop", {eng_grant, host_grant}, 0);
      wr(16'h0000);
      step(); chk("R2 arbitration back", {eng_grant, host_grant}, 2);

      finish_run();
   end
endmodule